// File: doc/BRIEF.md
# Posted Write Ordering Gate

This block sits between an I/O device and host memory. It accepts a stream of posted writes. Each write carries an address, a data word and a fence flag. The block hands each write to one of two memory paths whose completion latencies differ, so a later write can become visible in memory before an earlier one. A device transfer is normally a burst of data writes and then one write to a status word. The producer sets the fence flag on that status write. The block then makes sure the status write cannot be seen in memory until every data write received before it has completed.

Two ordering modes exist. In relaxed mode, which is the mode after reset, unflagged writes flow to both paths back to back and may complete in any order across paths. Only a flagged write is held until no earlier write is still in flight. In strict mode every write waits until the previous one has been acknowledged, so writes complete in arrival order, at a cost in throughput. A saturating counter reports how many cycles the head of the queue spent blocked by an ordering rule, which exposes the bandwidth cost of each mode.

Back-pressure rules:
- The input is valid/ready. A write transfers on a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends only on the fill level of the input queue.
- Each memory path is valid/ready as well. Once a path's `valid` is high, it stays high with a stable address and data until that path's `ready` is seen.
- Each path returns a one-cycle `ack` per completed write. Within a path, acks come back in issue order.

Top module: `wr_order_unit`

## Requirements
- R1: After reset, both path valids are low, `in_ready` is high, `order_stall_cycles` is 0 and the mode is relaxed.
- R2: A write is sent to path 1 when address bit `SEL_BIT` (default 6) is 1, and to path 0 otherwise. Address and data are passed through unchanged, and writes leave in arrival order.
- R3: In relaxed mode an unflagged write at the head is issued even while earlier writes are outstanding.
- R4: A flagged write (`in_fence`=1) at the head is not offered to any path while any issued write is unacknowledged. Writes behind it wait too.
- R5: When a flagged write is issued, every write received before it has already been acknowledged.
- R6: In strict mode a write is offered only when no write is outstanding, so acknowledgements arrive in arrival order.
- R7: The mode register takes `strict_en` on each clock: 1 selects strict and 0 selects relaxed. The new mode applies from the following cycle.
- R8: `in_ready` is high exactly when the input queue holds fewer than `DEPTH` (default 4) writes. A push and a pop may happen in the same cycle.
- R9: A path valid that is not accepted stays high next cycle with the same address and data, whatever the mode or fence state.
- R10: `order_stall_cycles` rises by one on each cycle where the head is valid, is not already being offered, and is blocked by the fence or strict rule. Cycles blocked only by the outstanding limit are not counted. The counter saturates.
- R11: No write is newly offered while `MAX_OUT` (default 8) writes are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en | input | 1 | Mode select: 1 strict, 0 relaxed |
| in_valid | input | 1 | Input write valid |
| in_ready | output | 1 | Input queue can accept a write |
| in_addr | input | ADDR_W | Write address |
| in_data | input | DATA_W | Write data |
| in_fence | input | 1 | Write must follow all earlier writes |
| p0_valid | output | 1 | Path 0 write valid |
| p0_ready | input | 1 | Path 0 accepts the write |
| p0_addr | output | ADDR_W | Path 0 address |
| p0_data | output | DATA_W | Path 0 data |
| p0_ack | input | 1 | Path 0 completed one write |
| p1_valid | output | 1 | Path 1 write valid |
| p1_ready | input | 1 | Path 1 accepts the write |
| p1_addr | output | ADDR_W | Path 1 address |
| p1_data | output | DATA_W | Path 1 data |
| p1_ack | input | 1 | Path 1 completed one write |
| order_stall_cycles | output | CNT_W | Saturating count of ordering stall cycles |

## Verification
The outstanding count is the main piece of hidden state. If it drifts, the fault shows within a cycle or two at the path valids. A count that is too high holds a fenced or strict write after its predecessors have drained, and the stall counter then runs ahead of the model on the same cycle. A count that is too low lets a fenced write out while an earlier write is still unacknowledged. The bench flags that at the moment of issue, because it compares against its own record of completions. A wrong head pointer or a wrong path select shows up as a payload or valid mismatch on the first cycle the write is offered.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic {
    ORD_RELAXED = 1'b0,
    ORD_STRICT  = 1'b1
  } ord_mode_e;

  localparam int NUM_PATHS = 2;
endpackage

// File: rtl/wo_fifo.sv
module wo_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         head_valid,
  output logic         can_push
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign head_data  = store[rd_ptr];
  assign head_valid = (fill != '0);
  assign can_push   = (fill != CW'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill < CW'(DEPTH)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill != '0));
endmodule

// File: rtl/wo_issue.sv
module wo_issue
  import wo_pkg::*;
#(
  parameter int MAX_OUT = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ord_mode_e            mode,
  input  logic                 head_valid,
  input  logic                 head_fence,
  input  logic                 head_path,
  input  logic [NUM_PATHS-1:0] path_ready,
  input  logic [NUM_PATHS-1:0] path_ack,
  output logic [NUM_PATHS-1:0] path_go,
  output logic                 issue,
  output logic                 order_stall
);
  localparam int OW = $clog2(MAX_OUT + 1);

  logic [OW-1:0] inflight;
  logic          held_q;
  logic          rule_ok, room, go;

  assign rule_ok = (inflight == '0) || ((mode == ORD_RELAXED) && !head_fence);
  assign room    = (inflight < OW'(MAX_OUT));
  assign go      = head_valid && (held_q || (rule_ok && room));

  assign path_go[0] = go && !head_path;
  assign path_go[1] = go &&  head_path;
  assign issue      = |(path_go & path_ready);
  assign order_stall = head_valid && !held_q && !rule_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= '0;
      held_q   <= 1'b0;
    end else begin
      inflight <= inflight + OW'(issue) - OW'(path_ack[0]) - OW'(path_ack[1]);
      held_q   <= go && !issue;
    end
  end

  // R4
  fence_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && head_fence) |-> (inflight == '0));

  // R6
  strict_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (mode == ORD_STRICT) && !held_q) |-> (inflight == '0));

  // R11
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= OW'(MAX_OUT));

  // R9
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|path_go) && !issue) |=> (path_go == $past(path_go)));
endmodule

// File: rtl/wo_stall_ctr.sv
module wo_stall_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (stall && (count != '1)) count <= count + 1'b1;
  end

  // R10
  stall_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (count != '0));
endmodule

// File: rtl/wr_order_unit.sv
module wr_order_unit
  import wo_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 8,
  parameter int SEL_BIT = 6,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_fence,
  output logic              p0_valid,
  input  logic              p0_ready,
  output logic [ADDR_W-1:0] p0_addr,
  output logic [DATA_W-1:0] p0_data,
  input  logic              p0_ack,
  output logic              p1_valid,
  input  logic              p1_ready,
  output logic [ADDR_W-1:0] p1_addr,
  output logic [DATA_W-1:0] p1_data,
  input  logic              p1_ack,
  output logic [CNT_W-1:0]  order_stall_cycles
);
  localparam int EW = 1 + ADDR_W + DATA_W;

  ord_mode_e    mode_q;
  logic [EW-1:0] head_ent;
  logic          head_valid, can_push, issue, order_stall;
  logic [NUM_PATHS-1:0] path_go, path_ready, path_ack;
  logic [ADDR_W-1:0]    head_addr;
  logic [DATA_W-1:0]    head_data;
  logic                 head_fence;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ORD_RELAXED;
    else        mode_q <= strict_en ? ORD_STRICT : ORD_RELAXED;
  end

  assign in_ready = can_push;

  wo_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && can_push), .push_data({in_fence, in_addr, in_data}),
    .pop(issue), .head_data(head_ent), .head_valid(head_valid),
    .can_push(can_push)
  );

  assign {head_fence, head_addr, head_data} = head_ent;
  assign path_ready = {p1_ready, p0_ready};
  assign path_ack   = {p1_ack, p0_ack};

  wo_issue #(.MAX_OUT(MAX_OUT)) u_issue (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .head_valid(head_valid), .head_fence(head_fence),
    .head_path(head_addr[SEL_BIT]),
    .path_ready(path_ready), .path_ack(path_ack),
    .path_go(path_go), .issue(issue), .order_stall(order_stall)
  );

  wo_stall_ctr #(.CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .stall(order_stall), .count(order_stall_cycles)
  );

  logic [ADDR_W-1:0] out_addr [NUM_PATHS];
  logic [DATA_W-1:0] out_data [NUM_PATHS];

  for (genvar gp = 0; gp < NUM_PATHS; gp++) begin : g_path
    assign out_addr[gp] = path_go[gp] ? head_addr : '0;
    assign out_data[gp] = path_go[gp] ? head_data : '0;
  end

  assign p0_valid = path_go[0];
  assign p1_valid = path_go[1];
  assign p0_addr  = out_addr[0];
  assign p0_data  = out_data[0];
  assign p1_addr  = out_addr[1];
  assign p1_data  = out_data[1];

  // R2
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_valid, p0_valid}));

  // R4
  fence_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p0_ready && head_fence) |-> !p1_valid);
endmodule

// File: tb/sim_wr_order_unit.sv
module sim_wr_order_unit;
  localparam int AW = 32, DW = 32, DEPTH = 4, MAXO = 8, SEL = 6, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strict_en = 1'b0, in_valid = 1'b0, in_fence = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic p0_ready = 1'b0, p1_ready = 1'b0, p0_ack = 1'b0, p1_ack = 1'b0;
  logic in_ready, p0_valid, p1_valid;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [DW-1:0] p0_data, p1_data;
  logic [CW-1:0] order_stall_cycles;

  always #5 clk = ~clk;

  wr_order_unit u0 (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_fence(in_fence),
    .p0_valid(p0_valid), .p0_ready(p0_ready), .p0_addr(p0_addr),
    .p0_data(p0_data), .p0_ack(p0_ack),
    .p1_valid(p1_valid), .p1_ready(p1_ready), .p1_addr(p1_addr),
    .p1_data(p1_data), .p1_ack(p1_ack),
    .order_stall_cycles(order_stall_cycles)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  logic [AW-1:0] mq_a[$];
  logic [DW-1:0] mq_d[$];
  bit mq_f[$];
  int mq_s[$];
  int m_ost = 0, m_stall = 0, max_ost = 0;
  bit m_held = 0, m_mode = 0, saw_overlap = 0;

  int due0[$], due1[$], sid0[$], sid1[$];
  bit done[0:4095];
  int next_seq = 0, last_ack = -1, last_due1 = 0;

  int p_valid = 0, p_fence = 0, p_rdy0 = 100, p_rdy1 = 100;
  bit strict_knob = 0, strict_check = 0, have_item = 0, sticky = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit hv, hf, hp, rule_ok, go, iss, acc, e0, e1, a0, a1;
    logic [AW-1:0] ha; logic [DW-1:0] hd;
    string lbl;
    int s;
    @(negedge clk);
    if (!have_item) begin
      in_addr  = $urandom;
      in_data  = $urandom;
      in_fence = (($urandom % 100) < p_fence);
      have_item = 1;
    end
    in_valid  = sticky || (($urandom % 100) < p_valid);
    p0_ready  = (($urandom % 100) < p_rdy0);
    p1_ready  = (($urandom % 100) < p_rdy1);
    strict_en = strict_knob;
    a0 = (due0.size() > 0) && (due0[0] <= cyc);
    a1 = (due1.size() > 0) && (due1[0] <= cyc);
    p0_ack = a0; p1_ack = a1;
    #1;
    hv = (mq_a.size() > 0);
    ha = hv ? mq_a[0] : '0; hd = hv ? mq_d[0] : '0;
    hf = hv ? mq_f[0] : 0;  hp = ha[SEL];
    rule_ok = (m_ost == 0) || (!m_mode && !hf);
    go = hv && (m_held || (rule_ok && m_ost < MAXO));
    e0 = go && !hp; e1 = go && hp;
    if (m_mode != strict_knob) lbl = "R7";
    else if (m_mode) lbl = "R6";
    else if (hf) lbl = "R4";
    else if (m_held) lbl = "R9";
    else if (m_ost == MAXO) lbl = "R11";
    else lbl = "R2";
    check(p0_valid == e0, lbl, "p0_valid", p0_valid, e0);
    check(p1_valid == e1, lbl, "p1_valid", p1_valid, e1);
    if (e0) check(p0_addr == ha && p0_data == hd, "R2", "p0 payload", p0_addr, ha);
    if (e1) check(p1_addr == ha && p1_data == hd, "R2", "p1 payload", p1_addr, ha);
    check(in_ready == (mq_a.size() < DEPTH), "R8", "in_ready", in_ready, mq_a.size() < DEPTH);
    check(order_stall_cycles == CW'(m_stall), "R10", "stall count", order_stall_cycles, m_stall);
    // update model for the coming edge
    iss = go && (hp ? p1_ready : p0_ready);
    acc = in_valid && (mq_a.size() < DEPTH);
    if (a0) begin
      void'(due0.pop_front()); s = sid0.pop_front(); done[s] = 1;
      if (strict_check) check(s == last_ack + 1, "R6", "ack order", s, last_ack + 1);
      last_ack = s;
    end
    if (a1) begin
      void'(due1.pop_front()); s = sid1.pop_front(); done[s] = 1;
      if (strict_check) check(s == last_ack + 1, "R6", "ack order", s, last_ack + 1);
      last_ack = s;
    end
    if (iss) begin
      s = mq_s[0];
      if (hf) begin
        int pend = 0;
        for (int k = 0; k < s; k++) if (!done[k]) pend++;
        check(pend == 0, "R5", "earlier writes pending at fence", pend, 0);
      end
      if (!m_mode && !hf && m_ost > 0) saw_overlap = 1;
      if (hp) begin
        last_due1 = (cyc + 3 + int'($urandom % 10) > last_due1) ? cyc + 3 + int'($urandom % 10) : last_due1 + 1;
        due1.push_back(last_due1); sid1.push_back(s);
      end else begin
        due0.push_back(cyc + 2); sid0.push_back(s);
      end
      void'(mq_a.pop_front()); void'(mq_d.pop_front());
      void'(mq_f.pop_front()); void'(mq_s.pop_front());
    end
    if (acc) begin
      mq_a.push_back(in_addr); mq_d.push_back(in_data);
      mq_f.push_back(in_fence); mq_s.push_back(next_seq);
      next_seq++; have_item = 0; sticky = 0;
    end else sticky = in_valid;
    if (hv && !m_held && !rule_ok) m_stall++;
    m_ost = m_ost + int'(iss) - int'(a0) - int'(a1);
    if (m_ost > max_ost) max_ost = m_ost;
    m_held = go && !iss;
    m_mode = strict_knob;
    cyc++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!p0_valid && !p1_valid, "R1", "path valids after reset", {p1_valid, p0_valid}, 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(order_stall_cycles == 0, "R1", "stall after reset", order_stall_cycles, 0);
    // relaxed, no fences, fast paths: overlap and the outstanding cap
    p_valid = 95; p_fence = 0;
    repeat (300) step();
    // relaxed with fenced status writes and path back-pressure
    p_fence = 15; p_rdy0 = 70; p_rdy1 = 60;
    repeat (600) step();
    // drain, then strict mode
    p_valid = 0;
    repeat (40) step();
    strict_knob = 1;
    repeat (3) step();
    strict_check = 1; p_valid = 80; p_fence = 10;
    repeat (400) step();
    strict_check = 0; strict_knob = 0;
    // relaxed, slow paths: fill the input queue
    p_valid = 100; p_fence = 5; p_rdy0 = 15; p_rdy1 = 15;
    repeat (300) step();
    p_valid = 0; p_rdy0 = 100; p_rdy1 = 100;
    repeat (80) step();
    check(saw_overlap, "R3", "relaxed issue with writes outstanding", saw_overlap, 1);
    check(max_ost == MAXO, "R11", "peak outstanding", max_ost, MAXO);
    check(m_stall > 0, "R10", "ordering stalls seen", m_stall, 1);
    check(m_ost == 0 && mq_a.size() == 0, "R5", "all writes drained", m_ost, 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule